// File: doc/BRIEF.md
# Calendar Clock with Alarm Match

The block keeps wall-clock time and a calendar: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-hertz tick from outside starts each update. The status bit goes high first. A fixed number of clock cycles later the time advances by one second. The status bit then stays high for a further tail and drops. Software therefore learns that an update is coming before any time byte moves.

A byte-wide register port reaches the time bytes, three alarm bytes (seconds, minutes, hours), a status byte and a control byte. Reads are combinational from the address. Writes take effect on the next clock edge. The control byte selects the data format (BCD or plain binary) and the hour mode (12-hour or 24-hour). It also holds a freeze bit that stops updates while software loads a new time. Stored bytes are kept in whatever format was selected when they were written. Each update also compares the new seconds, minutes and hours with the alarm bytes, and a full match gives a one-cycle alarm pulse.

Top module: `rtc_calendar_clock`

## Requirements
- R1: After reset the time reads 00:00:00, day of week 1, day of month 1, month 1, year 0. All alarm bytes read 0, control reads 0x02, and the status byte, `uip_o` and `alarm_o` are all 0.
- R2: Register indices: 0 seconds, 1 seconds alarm, 2 minutes, 3 minutes alarm, 4 hours, 5 hours alarm, 6 day of week, 7 day of month, 8 month, 9 year, 10 status, 11 control. Status bit 7 mirrors `uip_o` and its other bits read 0. Status is read-only, and indices 12 to 15 read 0.
- R3: Seconds and minutes count 0 to 59 and carry when they wrap. In 24-hour mode (control bit 1 set) hours count 0 to 23, and the wrap carries into the day.
- R4: In 12-hour mode (control bit 1 clear), hours bit 7 flags PM and bits 6:0 hold 1 to 12. Going from 11 to 12 toggles PM, and going from 12 to 1 keeps it. Only the PM 11 to AM 12 step carries into the day.
- R5: On a day carry, day of week wraps from 7 to 1. Day of month wraps to 1 after the month's last day: 30 for months 4, 6, 9 and 11, and 31 for the other months except February. February has 29 days when the year is divisible by four and 28 otherwise. Month wraps from 12 to 1 and carries into the year, and the year wraps from 99 to 0.
- R6: Control bit 2 clear means every time byte is BCD, and set means plain binary. Changing the bit does not convert the bytes already stored.
- R7: A tick accepted while idle with the freeze bit clear raises `uip_o` at the following edge. The time advances on the LEAD_CYC-th edge after the tick edge. `uip_o` stays high for exactly LEAD_CYC+HOLD_CYC cycles. Ticks that arrive while `uip_o` is high are ignored.
- R8: While control bit 7 (freeze) is set, ticks are ignored, `uip_o` stays low and the time bytes do not advance.
- R9: A write to a time byte is dropped while `uip_o` is high and the freeze bit is clear. Alarm and control writes are always taken.
- R10: `alarm_o` pulses for one cycle on the update edge when seconds, minutes and hours all match their alarm bytes. An alarm byte with bits 7 and 6 both set matches any value of its field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse once per second |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register index |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| uip_o | output | 1 | Update in progress |
| alarm_o | output | 1 | One-cycle alarm match pulse |

## Verification
The assertions check the invariants that hold on every cycle. The alarm pulse is a single cycle and appears only inside an update window. A frozen idle clock never starts a window. The seconds byte cannot move during a window except on the update edge. A window never runs longer than LEAD_CYC+HOLD_CYC cycles. The calendar arithmetic needs the bench's scenarios and its reference model: month lengths, leap February, year wrap, the 12-hour PM handling, both data formats, don't-care alarm bytes and the dropped write during an update.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam logic [3:0] IX_SEC    = 4'd0;
    localparam logic [3:0] IX_SEC_AL = 4'd1;
    localparam logic [3:0] IX_MIN    = 4'd2;
    localparam logic [3:0] IX_MIN_AL = 4'd3;
    localparam logic [3:0] IX_HR     = 4'd4;
    localparam logic [3:0] IX_HR_AL  = 4'd5;
    localparam logic [3:0] IX_DOW    = 4'd6;
    localparam logic [3:0] IX_DOM    = 4'd7;
    localparam logic [3:0] IX_MON    = 4'd8;
    localparam logic [3:0] IX_YR     = 4'd9;
    localparam logic [3:0] IX_STAT   = 4'd10;
    localparam logic [3:0] IX_CTL    = 4'd11;

    localparam int CTL_FREEZE = 7;
    localparam int CTL_BIN    = 2;
    localparam int CTL_H24    = 1;
    localparam logic [7:0] CTL_RESET = 8'h02;

    typedef enum logic [1:0] {PH_IDLE, PH_LEAD, PH_TAIL} upd_phase_e;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] dow;
        logic [7:0] dom;
        logic [7:0] mon;
        logic [7:0] year;
    } cal_t;

    typedef struct packed {
        cal_t       tm;
        logic [7:0] al_sec;
        logic [7:0] al_min;
        logic [7:0] al_hr;
        logic [7:0] ctl;
        logic       alarm;
    } clk_state_t;

    function automatic logic [7:0] to_bin(input logic [7:0] v, input logic is_bin);
        return is_bin ? v : (({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]});
    endfunction

    function automatic logic [7:0] from_bin(input logic [7:0] v, input logic is_bin);
        logic [7:0] tens;
        logic [7:0] ones;
        tens = v / 8'd10;
        ones = v % 8'd10;
        return is_bin ? v : {tens[3:0], ones[3:0]};
    endfunction

    function automatic logic [7:0] month_len(input logic [7:0] mon_b, input logic [7:0] yr_b);
        logic [7:0] len;
        case (mon_b)
            8'd4, 8'd6, 8'd9, 8'd11: len = 8'd30;
            8'd2:                    len = (yr_b[1:0] == 2'b00) ? 8'd29 : 8'd28;
            default:                 len = 8'd31;
        endcase
        return len;
    endfunction

endpackage

// File: rtl/rtc_upd_seq.sv
module rtc_upd_seq
    import rtc_cal_pkg::*;
#(
    parameter int LEAD_CYC = 4,
    parameter int HOLD_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic freeze,
    output logic busy,
    output logic apply
);
    localparam int MAXC  = (LEAD_CYC > HOLD_CYC) ? LEAD_CYC : HOLD_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    typedef struct packed {
        upd_phase_e       ph;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        apply = 1'b0;
        case (s_q.ph)
            PH_IDLE: begin
                if (tick && !freeze) begin
                    s_d.ph  = PH_LEAD;
                    s_d.cnt = CNT_W'(LEAD_CYC - 1);
                end
            end
            PH_LEAD: begin
                if (s_q.cnt == '0) begin
                    apply   = !freeze;
                    s_d.ph  = PH_TAIL;
                    s_d.cnt = CNT_W'(HOLD_CYC - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_TAIL: begin
                if (s_q.cnt == '0) s_d.ph = PH_IDLE;
                else               s_d.cnt = s_q.cnt - 1'b1;
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ph  <= PH_IDLE;
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = (s_q.ph != PH_IDLE);

endmodule

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
    import rtc_cal_pkg::*;
(
    input  cal_t cur,
    input  logic is_bin,
    input  logic mode24,
    output cal_t nxt
);
    logic [7:0] s_b, mi_b, h_b, dw_b, dm_b, mo_b, yr_b, dim, h_n, h_enc;
    logic       c_min, c_hr, c_day, c_mon, c_yr, pm_n;

    always_comb begin
        nxt   = cur;
        s_b   = to_bin(cur.sec, is_bin);
        mi_b  = to_bin(cur.min, is_bin);
        h_b   = mode24 ? to_bin(cur.hour, is_bin) : to_bin({1'b0, cur.hour[6:0]}, is_bin);
        dw_b  = to_bin(cur.dow, is_bin);
        dm_b  = to_bin(cur.dom, is_bin);
        mo_b  = to_bin(cur.mon, is_bin);
        yr_b  = to_bin(cur.year, is_bin);
        dim   = month_len(mo_b, yr_b);
        c_hr  = 1'b0;
        c_day = 1'b0;
        c_mon = 1'b0;
        c_yr  = 1'b0;
        pm_n  = cur.hour[7];
        h_n   = h_b;
        h_enc = 8'd0;

        c_min   = (s_b == 8'd59);
        nxt.sec = from_bin(c_min ? 8'd0 : s_b + 8'd1, is_bin);

        if (c_min) begin
            c_hr    = (mi_b == 8'd59);
            nxt.min = from_bin(c_hr ? 8'd0 : mi_b + 8'd1, is_bin);
        end

        if (c_hr) begin
            if (mode24) begin
                c_day    = (h_b == 8'd23);
                nxt.hour = from_bin(c_day ? 8'd0 : h_b + 8'd1, is_bin);
            end else begin
                if (h_b == 8'd11) begin
                    h_n   = 8'd12;
                    pm_n  = ~cur.hour[7];
                    c_day = cur.hour[7];
                end else if (h_b == 8'd12) begin
                    h_n = 8'd1;
                end else begin
                    h_n = h_b + 8'd1;
                end
                h_enc    = from_bin(h_n, is_bin);
                nxt.hour = {pm_n, h_enc[6:0]};
            end
        end

        if (c_day) begin
            nxt.dow = from_bin((dw_b == 8'd7) ? 8'd1 : dw_b + 8'd1, is_bin);
            c_mon   = (dm_b == dim);
            nxt.dom = from_bin(c_mon ? 8'd1 : dm_b + 8'd1, is_bin);
        end

        if (c_mon) begin
            c_yr    = (mo_b == 8'd12);
            nxt.mon = from_bin(c_yr ? 8'd1 : mo_b + 8'd1, is_bin);
        end

        if (c_yr) begin
            nxt.year = from_bin((yr_b == 8'd99) ? 8'd0 : yr_b + 8'd1, is_bin);
        end
    end

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
    parameter int NF = 3
) (
    input  logic [NF-1:0][7:0] cur,
    input  logic [NF-1:0][7:0] alm,
    output logic               hit
);
    logic [NF-1:0] fld_ok;

    for (genvar i = 0; i < NF; i++) begin : g_fld
        assign fld_ok[i] = (alm[i][7:6] == 2'b11) || (alm[i] == cur[i]);
    end

    assign hit = &fld_ok;

endmodule

// File: rtl/rtc_calendar_clock.sv
module rtc_calendar_clock
    import rtc_cal_pkg::*;
#(
    parameter int LEAD_CYC = 4,
    parameter int HOLD_CYC = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       wr_en_i,
    input  logic [3:0] addr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    output logic       uip_o,
    output logic       alarm_o
);
    localparam int NFLD = 3;

    clk_state_t r_d, r_q;
    cal_t       tm_step;
    logic       seq_busy, seq_apply, al_hit, time_wr_ok;
    logic       hold_w;
    logic [7:0] sec_w;

    assign hold_w = r_q.ctl[CTL_FREEZE];
    assign sec_w  = r_q.tm.sec;

    rtc_upd_seq #(
        .LEAD_CYC(LEAD_CYC),
        .HOLD_CYC(HOLD_CYC)
    ) seq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_i),
        .freeze(hold_w),
        .busy  (seq_busy),
        .apply (seq_apply)
    );

    rtc_cal_step step_i (
        .cur   (r_q.tm),
        .is_bin(r_q.ctl[CTL_BIN]),
        .mode24(r_q.ctl[CTL_H24]),
        .nxt   (tm_step)
    );

    rtc_alarm_match #(.NF(NFLD)) match_i (
        .cur({tm_step.hour, tm_step.min, tm_step.sec}),
        .alm({r_q.al_hr, r_q.al_min, r_q.al_sec}),
        .hit(al_hit)
    );

    assign time_wr_ok = hold_w || !seq_busy;

    always_comb begin
        r_d       = r_q;
        r_d.alarm = 1'b0;
        if (seq_apply) begin
            r_d.tm    = tm_step;
            r_d.alarm = al_hit;
        end
        if (wr_en_i) begin
            case (addr_i)
                IX_SEC:    if (time_wr_ok) r_d.tm.sec  = wdata_i;
                IX_MIN:    if (time_wr_ok) r_d.tm.min  = wdata_i;
                IX_HR:     if (time_wr_ok) r_d.tm.hour = wdata_i;
                IX_DOW:    if (time_wr_ok) r_d.tm.dow  = wdata_i;
                IX_DOM:    if (time_wr_ok) r_d.tm.dom  = wdata_i;
                IX_MON:    if (time_wr_ok) r_d.tm.mon  = wdata_i;
                IX_YR:     if (time_wr_ok) r_d.tm.year = wdata_i;
                IX_SEC_AL: r_d.al_sec = wdata_i;
                IX_MIN_AL: r_d.al_min = wdata_i;
                IX_HR_AL:  r_d.al_hr  = wdata_i;
                IX_CTL:    r_d.ctl    = wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.tm.sec  <= 8'd0;
            r_q.tm.min  <= 8'd0;
            r_q.tm.hour <= 8'd0;
            r_q.tm.dow  <= 8'd1;
            r_q.tm.dom  <= 8'd1;
            r_q.tm.mon  <= 8'd1;
            r_q.tm.year <= 8'd0;
            r_q.al_sec  <= 8'd0;
            r_q.al_min  <= 8'd0;
            r_q.al_hr   <= 8'd0;
            r_q.ctl     <= CTL_RESET;
            r_q.alarm   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (addr_i)
            IX_SEC:    rdata_o = r_q.tm.sec;
            IX_SEC_AL: rdata_o = r_q.al_sec;
            IX_MIN:    rdata_o = r_q.tm.min;
            IX_MIN_AL: rdata_o = r_q.al_min;
            IX_HR:     rdata_o = r_q.tm.hour;
            IX_HR_AL:  rdata_o = r_q.al_hr;
            IX_DOW:    rdata_o = r_q.tm.dow;
            IX_DOM:    rdata_o = r_q.tm.dom;
            IX_MON:    rdata_o = r_q.tm.mon;
            IX_YR:     rdata_o = r_q.tm.year;
            IX_STAT:   rdata_o = {seq_busy, 7'd0};
            IX_CTL:    rdata_o = r_q.ctl;
            default:   rdata_o = 8'd0;
        endcase
    end

    assign uip_o   = seq_busy;
    assign alarm_o = r_q.alarm;

endmodule

// File: rtl/rtc_calendar_clock_chk.sv
module rtc_calendar_clock_chk #(
    parameter int LEAD_CYC = 4,
    parameter int HOLD_CYC = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       uip,
    input logic       alarm,
    input logic       hold,
    input logic       apply,
    input logic [7:0] sec
);
    localparam int WIN = LEAD_CYC + HOLD_CYC;

    logic [15:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   run_q <= '0;
        else if (uip) run_q <= run_q + 16'd1;
        else          run_q <= '0;
    end

    p_alarm_in_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |-> uip);

    p_alarm_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |=> !alarm);

    p_freeze_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !uip) |=> !uip);

    p_sec_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (uip && !hold && !apply) |=> $stable(sec));

    p_apply_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        apply |-> uip);

    p_window_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        uip |-> (run_q < 16'(WIN)));

endmodule

bind rtc_calendar_clock rtc_calendar_clock_chk #(
    .LEAD_CYC(LEAD_CYC),
    .HOLD_CYC(HOLD_CYC)
) chk_i (
    .clk  (clk),
    .rst_n(rst_n),
    .uip  (uip_o),
    .alarm(alarm_o),
    .hold (hold_w),
    .apply(seq_apply),
    .sec  (sec_w)
);

// File: tb/rtc_calendar_clock_tb_top.sv
module rtc_calendar_clock_tb_top;
    localparam int LEAD = 4;
    localparam int HOLD = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [3:0] addr_i = 4'd0;
    logic [7:0] wdata_i = 8'd0;
    logic [7:0] rdata_o;
    logic       uip_o, alarm_o;

    int n_chk = 0;
    int n_err = 0;
    bit cmp_en = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rtc_calendar_clock #(.LEAD_CYC(LEAD), .HOLD_CYC(HOLD)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .uip_o(uip_o), .alarm_o(alarm_o)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int m_reg[0:9];
    int m_ctl, m_ph, m_cnt;
    bit m_alarm;

    function automatic int tb(input int v);
        return m_ctl[2] ? v : ((v >> 4) * 10 + (v & 15));
    endfunction

    function automatic int fb(input int v);
        return m_ctl[2] ? v : (((v / 10) << 4) | (v % 10));
    endfunction

    function automatic void m_init();
        for (int i = 0; i < 10; i++) m_reg[i] = 0;
        m_reg[6] = 1; m_reg[7] = 1; m_reg[8] = 1;
        m_ctl = 2; m_ph = 0; m_cnt = 0; m_alarm = 0;
    endfunction

    function automatic void m_advance();
        int v, pm, dim, mo, yr;
        v = tb(m_reg[0]);
        if (v < 59) begin m_reg[0] = fb(v + 1); return; end
        m_reg[0] = fb(0);
        v = tb(m_reg[2]);
        if (v < 59) begin m_reg[2] = fb(v + 1); return; end
        m_reg[2] = fb(0);
        if (m_ctl[1]) begin
            v = tb(m_reg[4]);
            if (v < 23) begin m_reg[4] = fb(v + 1); return; end
            m_reg[4] = fb(0);
        end else begin
            pm = (m_reg[4] >> 7) & 1;
            v  = tb(m_reg[4] & 127);
            if (v == 12) begin m_reg[4] = (pm << 7) | fb(1); return; end
            if (v != 11) begin m_reg[4] = (pm << 7) | fb(v + 1); return; end
            m_reg[4] = ((1 - pm) << 7) | fb(12);
            if (pm == 0) return;
        end
        v = tb(m_reg[6]);
        m_reg[6] = fb(v == 7 ? 1 : v + 1);
        mo = tb(m_reg[8]);
        yr = tb(m_reg[9]);
        if (mo == 2) dim = (yr % 4 == 0) ? 29 : 28;
        else if (mo == 4 || mo == 6 || mo == 9 || mo == 11) dim = 30;
        else dim = 31;
        v = tb(m_reg[7]);
        if (v < dim) begin m_reg[7] = fb(v + 1); return; end
        m_reg[7] = fb(1);
        if (mo < 12) begin m_reg[8] = fb(mo + 1); return; end
        m_reg[8] = fb(1);
        m_reg[9] = fb(yr == 99 ? 0 : yr + 1);
    endfunction

    function automatic bit fld_ok(input int a, input int c);
        return ((a & 8'hC0) == 8'hC0) || (a == c);
    endfunction

    function automatic int m_read(input int a);
        if (a <= 9) return m_reg[a];
        if (a == 10) return (m_ph != 0) ? 8'h80 : 0;
        if (a == 11) return m_ctl;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) m_init();
        else begin
            bit frz, app, busy;
            frz = m_ctl[7];
            busy = (m_ph != 0);
            app = (m_ph == 1) && (m_cnt == 0) && !frz;
            m_alarm = 0;
            if (app) begin
                m_advance();
                m_alarm = fld_ok(m_reg[1], m_reg[0]) && fld_ok(m_reg[3], m_reg[2])
                          && fld_ok(m_reg[5], m_reg[4]);
            end
            case (m_ph)
                0: if (tick_i && !frz) begin m_ph = 1; m_cnt = LEAD - 1; end
                1: if (m_cnt == 0) begin m_ph = 2; m_cnt = HOLD - 1; end else m_cnt--;
                default: if (m_cnt == 0) m_ph = 0; else m_cnt--;
            endcase
            if (wr_en_i) begin
                int a;
                a = int'(addr_i);
                if (a == 1 || a == 3 || a == 5) m_reg[a] = int'(wdata_i);
                else if (a <= 9 && (frz || !busy)) m_reg[a] = int'(wdata_i);
                else if (a == 11) m_ctl = int'(wdata_i);
            end
        end
    end

    // per-cycle comparison and monitors
    bit alarm_seen = 0, uip_seen = 0;
    int run = 0, last_run = 0;

    always @(negedge clk) begin
        if (cmp_en) begin
            check("R7 uip_o vs model", int'(uip_o), (m_ph != 0) ? 1 : 0);
            check("R10 alarm_o vs model", int'(alarm_o), int'(m_alarm));
            check("R2 rdata vs model", int'(rdata_o), m_read(int'(addr_i)));
            if (alarm_o) alarm_seen = 1;
            if (uip_o) begin uip_seen = 1; run++; end
            else begin if (run > 0) last_run = run; run = 0; end
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic wr(input int a, input int d);
        wr_en_i = 1'b1; addr_i = 4'(a); wdata_i = 8'(d);
        cyc();
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input int a, input int exp, input string tag);
        addr_i = 4'(a);
        @(negedge clk); #1;
        check(tag, int'(rdata_o), exp);
        cyc();
    endtask

    task automatic do_tick();
        tick_i = 1'b1;
        cyc();
        tick_i = 1'b0;
        repeat (LEAD + HOLD + 2) cyc();
    endtask

    task automatic load(input int ctl, input int s, input int mi, input int h,
                        input int dw, input int dm, input int mo, input int y);
        wr(11, ctl | 8'h80);
        wr(0, s); wr(2, mi); wr(4, h); wr(6, dw); wr(7, dm); wr(8, mo); wr(9, y);
        wr(11, ctl);
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        cmp_en = 1;

        // R1 reset values
        rd(0, 8'h00, "R1 sec"); rd(2, 8'h00, "R1 min"); rd(4, 8'h00, "R1 hour");
        rd(6, 8'h01, "R1 dow"); rd(7, 8'h01, "R1 dom"); rd(8, 8'h01, "R1 mon");
        rd(9, 8'h00, "R1 year"); rd(1, 8'h00, "R1 sec alarm");
        rd(11, 8'h02, "R1 ctl"); rd(10, 8'h00, "R1 status");
        rd(13, 8'h00, "R2 unused index");

        // R3 R5 BCD end of year rollover
        load(8'h02, 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        do_tick();
        rd(0, 8'h00, "R3 sec wrap"); rd(2, 8'h00, "R3 min wrap"); rd(4, 8'h00, "R3 hour wrap");
        rd(6, 8'h01, "R5 dow wrap"); rd(7, 8'h01, "R5 dom wrap");
        rd(8, 8'h01, "R5 month wrap"); rd(9, 8'h00, "R5 year wrap");

        // R5 leap February
        load(8'h02, 8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
        do_tick();
        rd(7, 8'h29, "R5 leap feb 29"); rd(8, 8'h02, "R5 leap month held");
        load(8'h02, 8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23);
        do_tick();
        rd(7, 8'h01, "R5 common feb end"); rd(8, 8'h03, "R5 march");
        load(8'h02, 8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h23);
        do_tick();
        rd(7, 8'h01, "R5 30-day month"); rd(8, 8'h05, "R5 may");

        // R6 binary format and no conversion on switch
        load(8'h06, 59, 59, 23, 2, 31, 1, 99);
        do_tick();
        rd(0, 0, "R6 bin sec"); rd(4, 0, "R6 bin hour"); rd(7, 1, "R6 bin dom");
        rd(8, 2, "R6 bin month"); rd(9, 99, "R6 bin year kept");
        load(8'h02, 8'h15, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        wr(11, 8'h06);
        rd(0, 8'h15, "R6 no conversion");

        // R4 12-hour mode
        load(8'h00, 8'h59, 8'h59, 8'h11, 8'h03, 8'h10, 8'h05, 8'h20);
        do_tick();
        rd(4, 8'h92, "R4 11AM to 12PM"); rd(6, 8'h03, "R4 no day carry at noon");
        load(8'h00, 8'h59, 8'h59, 8'h92, 8'h03, 8'h10, 8'h05, 8'h20);
        do_tick();
        rd(4, 8'h81, "R4 12PM to 1PM");
        load(8'h00, 8'h59, 8'h59, 8'h91, 8'h03, 8'h10, 8'h05, 8'h20);
        do_tick();
        rd(4, 8'h12, "R4 11PM to 12AM"); rd(6, 8'h04, "R4 midnight day carry");

        // R10 alarm match, don't-care, mismatch
        load(8'h02, 8'h29, 8'h20, 8'h10, 8'h01, 8'h01, 8'h01, 8'h00);
        wr(1, 8'h30); wr(3, 8'h20); wr(5, 8'h10);
        alarm_seen = 0;
        do_tick();
        check("R10 exact alarm", int'(alarm_seen), 1);
        wr(1, 8'h31); wr(5, 8'hC0);
        alarm_seen = 0;
        do_tick();
        check("R10 dont-care hour alarm", int'(alarm_seen), 1);
        wr(1, 8'h45);
        alarm_seen = 0;
        do_tick();
        check("R10 mismatch no alarm", int'(alarm_seen), 0);

        // R8 freeze ignores ticks
        wr(11, 8'h82);
        uip_seen = 0;
        do_tick();
        check("R8 no uip while frozen", int'(uip_seen), 0);
        rd(0, 8'h32, "R8 time frozen");

        // R7 R9 window, status bit, dropped write
        load(8'h02, 8'h05, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        tick_i = 1'b1;
        cyc();
        tick_i = 1'b0;
        rd(10, 8'h80, "R7 status bit during update");
        wr(0, 8'h40);
        tick_i = 1'b1;
        cyc();
        tick_i = 1'b0;
        repeat (LEAD + HOLD + 2) cyc();
        rd(0, 8'h06, "R9 write dropped, one advance");
        check("R7 window length", last_run, LEAD + HOLD);
        rd(10, 8'h00, "R7 status clear after window");

        done = 1;
        cmp_en = 0;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule